// File: doc/BRIEF.md
# Sprite Line Binner

This block turns a linked sprite attribute table into per-scanline sprite lists. After a start command it reads table entry 0 through a synchronous read port, then follows each entry's link field to the next entry. Each visited sprite has a number: its position in the visit order, starting at 0. That number is appended to the list of every visible scanline the sprite covers.

When the walk ends, a done flag rises. A renderer can then read any line's list through a registered query port, giving a line and a slot. Each list holds a fixed number of entries. Hits beyond that number are dropped and mark the line as overflowed. A cap on the number of visits stops a link chain that loops back on itself.

Top module: `sprite_line_binner`

## Requirements
- R1: A start pulse accepted while idle raises `rd_en` for exactly one cycle with `rd_addr` equal to 0.
- R2: `rd_data` is sampled two cycles after the edge that raised `rd_en`. It packs the link in bits [3:0], the size field in bits [5:4] and a signed two's-complement y position in bits [14:6]. After a sprite is binned, the next read targets the sprite's link, and the walk ends after a sprite whose link is 0.
- R3: A sprite with size field s covers (s+1)*8 consecutive lines, starting at line y.
- R4: A covered line receives the sprite number only if it lies in 0 .. scr_cells*8-1. Lines above the top and below the screen are skipped, so a sprite can be partly clipped.
- R5: Each line's list holds sprite numbers in visit order, slot 0 first, and `q_count` gives the list length.
- R6: A line holds at most LINE_CAP entries. A further hit leaves the list unchanged and sets that line's `q_ovf`.
- R7: The walk stops after MAX_VISIT sprites, even when links remain.
- R8: Accepting a start empties every list and clears every overflow flag. The same holds after reset.
- R9: `done` falls at the accepting edge and rises T edges later, where T is the sum over visited sprites of 2 + lines covered. Lines covered includes clipped lines. A start during a walk is ignored.
- R10: `q_count`, `q_ovf` and `q_index` reflect `q_line`/`q_slot` one clock later. `q_index` is defined for slots below the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new build |
| scr_cells | input | 4 | Screen height in 8-line cells (1..MAX_CELLS) |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | 4 | Table entry to read |
| rd_data | input | 15 | Entry: y, size field, link |
| q_line | input | 6 | Query line |
| q_slot | input | 2 | Query slot |
| q_index | output | 4 | Sprite number in that slot |
| q_count | output | 3 | Entries in that line's list |
| q_ovf | output | 1 | Line dropped at least one hit |
| done | output | 1 | Build finished |

## Verification
`done` is due exactly T edges after the edge that accepts start, where T comes from the bench's own walk of the table. The bench checks that `done` is still low one edge earlier and high at that edge, and it places a second start in the middle of the walk. Query results are due one edge after the query is presented. Each expected item carries the cycle number at which it falls due, and the monitor compares it at the falling edge of that cycle. The table model logs every read address, so the visit order is checked against the expected chain.

// File: rtl/sbin_pkg.sv
package sbin_pkg;
  localparam int SZ_W = 2;
  localparam int CELL_SHIFT = 3;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_FETCH,
    WK_LATCH,
    WK_SCAN
  } wk_state_e;
endpackage

// File: rtl/sbin_line_ram.sv
module sbin_line_ram #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbin_count_bank.sv
module sbin_count_bank #(
  parameter int NLINES = 64,
  parameter int CAP    = 4,
  parameter int LINE_W = 6,
  parameter int SLOT_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic [LINE_W-1:0] hit_line,
  output logic [SLOT_W-1:0] slot,
  output logic              full,
  input  logic [LINE_W-1:0] q_line,
  output logic [CNT_W-1:0]  q_cnt,
  output logic              q_ovf
);
  logic [CNT_W-1:0]  cnt_q [NLINES];
  logic [NLINES-1:0] ovf_q;
  logic [CNT_W-1:0]  cur;

  assign cur  = cnt_q[hit_line];
  assign full = (cur == CNT_W'(CAP));
  assign slot = cur[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NLINES; i++) cnt_q[i] <= '0;
      ovf_q <= '0;
    end else if (hit) begin
      if (full) ovf_q[hit_line] <= 1'b1;
      else      cnt_q[hit_line] <= cur + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '0;
      q_ovf <= 1'b0;
    end else begin
      q_cnt <= cnt_q[q_line];
      q_ovf <= ovf_q[q_line];
    end
  end

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ovf_q == '0)); // R8
  AST_FULL_MARKS: assert property (@(posedge clk) disable iff (rst)
    (hit && full) |=> ovf_q[$past(hit_line)]); // R6
  AST_APPEND_STEP: assert property (@(posedge clk) disable iff (rst)
    (hit && !full) |=> (cnt_q[$past(hit_line)] == $past(cur) + 1'b1)); // R5
endmodule

// File: rtl/sbin_walker.sv
module sbin_walker
  import sbin_pkg::*;
#(
  parameter int Y_W       = 9,
  parameter int LINK_W    = 4,
  parameter int MAX_VISIT = 16,
  parameter int NLINES    = 64,
  parameter int LINE_W    = 6,
  parameter int SCR_W     = 4,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SCR_W-1:0]  scr_cells,
  output logic              rd_en,
  output logic [LINK_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              clr,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              done
);
  localparam int SUM_W = Y_W + 1;
  localparam int LEN_W = SZ_W + CELL_SHIFT + 1;
  localparam int VIS_W = IDX_W + 1;

  wk_state_e         state_q;
  logic [Y_W-1:0]    y_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  off_q;
  logic [LINK_W-1:0] link_q;
  logic [VIS_W-1:0]  vis_q;

  logic [LINK_W-1:0] f_link;
  logic [SZ_W-1:0]   f_size;
  logic [Y_W-1:0]    f_ypos;
  logic [SUM_W-1:0]  cur_line;
  logic [SUM_W-1:0]  scr_lim;
  logic              on_screen;
  logic              last_line;
  logic              stop_walk;

  assign f_link = rd_data[LINK_W-1:0];
  assign f_size = rd_data[LINK_W +: SZ_W];
  assign f_ypos = rd_data[LINK_W+SZ_W +: Y_W];

  assign cur_line  = {y_q[Y_W-1], y_q} + SUM_W'(off_q);
  assign scr_lim   = SUM_W'(scr_cells) << CELL_SHIFT;
  assign on_screen = !cur_line[SUM_W-1] && (cur_line < scr_lim)
                     && (cur_line < SUM_W'(NLINES));
  assign last_line = (off_q == len_q - 1'b1);
  assign stop_walk = (link_q == '0) || (vis_q == VIS_W'(MAX_VISIT - 1));

  assign clr      = (state_q == WK_IDLE) && start;
  assign hit      = (state_q == WK_SCAN) && on_screen;
  assign hit_line = cur_line[LINE_W-1:0];
  assign hit_idx  = vis_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WK_IDLE;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      y_q     <= '0;
      len_q   <= '0;
      off_q   <= '0;
      link_q  <= '0;
      vis_q   <= '0;
      done    <= 1'b0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (start) begin
            state_q <= WK_FETCH;
            rd_en   <= 1'b1;
            rd_addr <= '0;
            vis_q   <= '0;
            done    <= 1'b0;
          end
        end
        WK_FETCH: begin
          rd_en   <= 1'b0;
          state_q <= WK_LATCH;
        end
        WK_LATCH: begin
          y_q     <= f_ypos;
          len_q   <= (LEN_W'(f_size) + 1'b1) << CELL_SHIFT;
          link_q  <= f_link;
          off_q   <= '0;
          state_q <= WK_SCAN;
        end
        WK_SCAN: begin
          if (last_line) begin
            vis_q <= vis_q + 1'b1;
            if (stop_walk) begin
              state_q <= WK_IDLE;
              done    <= 1'b1;
            end else begin
              state_q <= WK_FETCH;
              rd_en   <= 1'b1;
              rd_addr <= link_q;
            end
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == WK_FETCH && $past(state_q) == WK_IDLE) |-> (rd_addr == '0)); // R1
  AST_CHASE_LINK: assert property (@(posedge clk) disable iff (rst)
    (state_q == WK_FETCH && $past(state_q) == WK_SCAN) |-> (rd_addr == $past(link_q))); // R2
  AST_VISIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    vis_q <= VIS_W'(MAX_VISIT)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en); // R1
endmodule

// File: rtl/sprite_line_binner.sv
module sprite_line_binner
  import sbin_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int Y_W       = 9,
  parameter int MAX_CELLS = 8,
  parameter int LINE_CAP  = 4,
  parameter int MAX_VISIT = 16,
  localparam int LINK_W   = $clog2(TBL_DEPTH),
  localparam int NLINES   = MAX_CELLS << CELL_SHIFT,
  localparam int LINE_W   = $clog2(NLINES),
  localparam int SCR_W    = $clog2(MAX_CELLS + 1),
  localparam int SLOT_W   = $clog2(LINE_CAP),
  localparam int CNT_W    = $clog2(LINE_CAP + 1),
  localparam int IDX_W    = $clog2(MAX_VISIT),
  localparam int DATA_W   = Y_W + SZ_W + LINK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SCR_W-1:0]  scr_cells,
  output logic              rd_en,
  output logic [LINK_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LINE_W-1:0] q_line,
  input  logic [SLOT_W-1:0] q_slot,
  output logic [IDX_W-1:0]  q_index,
  output logic [CNT_W-1:0]  q_count,
  output logic              q_ovf,
  output logic              done
);
  logic              clr;
  logic              hit;
  logic [LINE_W-1:0] hit_line;
  logic [IDX_W-1:0]  hit_idx;
  logic [SLOT_W-1:0] slot;
  logic              full;
  logic              ram_we;

  assign ram_we = hit && !full;

  sbin_walker #(
    .Y_W(Y_W), .LINK_W(LINK_W), .MAX_VISIT(MAX_VISIT), .NLINES(NLINES),
    .LINE_W(LINE_W), .SCR_W(SCR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_walk (
    .clk(clk), .rst(rst), .start(start), .scr_cells(scr_cells),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr(clr), .hit(hit), .hit_line(hit_line), .hit_idx(hit_idx),
    .done(done)
  );

  sbin_count_bank #(
    .NLINES(NLINES), .CAP(LINE_CAP), .LINE_W(LINE_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .hit(hit), .hit_line(hit_line),
    .slot(slot), .full(full), .q_line(q_line), .q_cnt(q_count),
    .q_ovf(q_ovf)
  );

  sbin_line_ram #(
    .AW(LINE_W + SLOT_W), .DW(IDX_W)
  ) u_ram (
    .clk(clk), .we(ram_we), .waddr({hit_line, slot}), .wdata(hit_idx),
    .raddr({q_line, q_slot}), .rdata(q_index)
  );

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (int'(hit_line) < (int'(scr_cells) << CELL_SHIFT))); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en); // R9
endmodule

// File: tb/sprite_line_binner_test.sv
module sprite_line_binner_test;
  localparam int CAP  = 4;
  localparam int NL   = 64;
  localparam int MAXV = 16;
  localparam int TD   = 16;

  typedef struct {
    int    line;
    int    slot;
    int    cnt;
    int    ovf;
    int    idx;
    int    due;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  scr_cells;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [14:0] rd_data;
  logic [5:0]  q_line;
  logic [1:0]  q_slot;
  logic [3:0]  q_index;
  logic [2:0]  q_count;
  logic        q_ovf;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  int t_y [TD];
  int t_sz [TD];
  int t_link [TD];
  int exp_cnt [NL];
  int exp_ovf [NL];
  int exp_idx [NL][CAP];
  int exp_addr [$];
  int addr_log [$];
  item_t sb [$];

  always #4 clk = ~clk;

  sprite_line_binner uut (
    .clk(clk), .rst(rst), .start(start), .scr_cells(scr_cells),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .q_line(q_line), .q_slot(q_slot), .q_index(q_index),
    .q_count(q_count), .q_ovf(q_ovf), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= {9'(t_y[rd_addr]), 2'(t_sz[rd_addr]), 4'(t_link[rd_addr])};
      addr_log.push_back(int'(rd_addr));
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      bit ok;
      it = sb.pop_front();
      ok = (int'(q_count) == it.cnt) && (int'(q_ovf) == it.ovf);
      if (it.slot < it.cnt) ok = ok && (int'(q_index) == it.idx);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s line %0d slot %0d: actual cnt %0d ovf %0d idx %0d expected cnt %0d ovf %0d idx %0d",
                 it.tag, it.line, it.slot, q_count, q_ovf, q_index, it.cnt, it.ovf, it.idx);
      end
    end
  end

  task automatic clear_table();
    for (int i = 0; i < TD; i++) begin
      t_y[i] = 0; t_sz[i] = 0; t_link[i] = 0;
    end
  endtask

  task automatic clear_model();
    for (int l = 0; l < NL; l++) begin
      exp_cnt[l] = 0;
      exp_ovf[l] = 0;
      for (int s = 0; s < CAP; s++) exp_idx[l][s] = 0;
    end
    exp_addr.delete();
  endtask

  task automatic build_model(input int scr, output int tcyc);
    int e;
    int vis;
    clear_model();
    e = 0; vis = 0; tcyc = 0;
    while (1) begin
      int lines;
      exp_addr.push_back(e);
      lines = (t_sz[e] + 1) * 8;
      for (int o = 0; o < lines; o++) begin
        int l;
        l = t_y[e] + o;
        if (l >= 0 && l < scr * 8) begin
          if (exp_cnt[l] < CAP) begin
            exp_idx[l][exp_cnt[l]] = vis;
            exp_cnt[l]++;
          end else begin
            exp_ovf[l] = 1;
          end
        end
      end
      tcyc += 2 + lines;
      vis++;
      if (t_link[e] == 0 || vis == MAXV) break;
      e = t_link[e];
    end
  endtask

  task automatic run_build(input int scr, input bit bump, input string seq_tag);
    int tcyc;
    build_model(scr, tcyc);
    addr_log.delete();
    scr_cells = 4'(scr);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(done == 1'b0, "R9", "done low after start", int'(done), 0);
    for (int c = 1; c < tcyc; c++) begin
      @(posedge clk); #1 start = bump && (c == 4);
    end
    start = 1'b0;
    chk(done == 1'b0, "R9", "done one edge early", int'(done), 0);
    @(posedge clk); #1;
    chk(done == 1'b1, "R9", "done at due edge", int'(done), 1);
    chk(addr_log.size() > 0 && addr_log[0] == 0, "R1", "first read address",
        addr_log.size() > 0 ? addr_log[0] : -1, 0);
    chk(addr_log.size() == exp_addr.size(), seq_tag, "read count",
        addr_log.size(), exp_addr.size());
    for (int i = 0; i < exp_addr.size() && i < addr_log.size(); i++)
      chk(addr_log[i] == exp_addr[i], "R2", "read address in chain", addr_log[i], exp_addr[i]);
  endtask

  task automatic drive_query(input int lo, input int hi, input string tag,
                             input string ovtag);
    for (int l = lo; l <= hi; l++) begin
      for (int s = 0; s < CAP; s++) begin
        item_t it;
        @(posedge clk); #1;
        q_line = 6'(l);
        q_slot = 2'(s);
        it.line = l;
        it.slot = s;
        it.cnt  = exp_cnt[l];
        it.ovf  = exp_ovf[l];
        it.idx  = (s < exp_cnt[l]) ? exp_idx[l][s] : -1;
        it.due  = cyc + 1;
        it.tag  = exp_ovf[l] != 0 ? ovtag : tag;
        sb.push_back(it);
      end
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; scr_cells = 4'd1; q_line = '0; q_slot = '0;
    clear_table();
    clear_model();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
    chk(rd_en == 1'b0, "R1", "rd_en after reset", int'(rd_en), 0);
    drive_query(5, 5, "R8", "R8");

    // R3 R4: clipped top, clipped bottom, fully above, mid-build start ignored
    clear_table();
    t_y[0] = -4;   t_sz[0] = 0; t_link[0] = 3;
    t_y[3] = 10;   t_sz[3] = 1; t_link[3] = 5;
    t_y[5] = 28;   t_sz[5] = 0; t_link[5] = 7;
    t_y[7] = -200; t_sz[7] = 3; t_link[7] = 0;
    run_build(4, 1'b1, "R2");
    drive_query(0, 7, "R4", "R4");
    drive_query(8, 27, "R3", "R3");
    drive_query(28, 40, "R4", "R4");

    // R5 R6: stacked sprites, order and overflow
    clear_table();
    for (int k = 0; k < 6; k++) begin
      t_y[k] = 20 + k; t_sz[k] = 0; t_link[k] = (k == 5) ? 0 : k + 1;
    end
    run_build(8, 1'b0, "R2");
    drive_query(16, 36, "R5", "R6");

    // R7: looping chain stopped at the visit cap
    clear_table();
    t_y[0] = 0;  t_sz[0] = 0; t_link[0] = 1;
    t_y[1] = 8;  t_sz[1] = 1; t_link[1] = 2;
    t_y[2] = -8; t_sz[2] = 3; t_link[2] = 1;
    run_build(8, 1'b0, "R7");
    drive_query(0, 31, "R7", "R6");

    // R8 R10: rebuild on a short screen empties old lists
    clear_table();
    t_y[0] = 4; t_sz[0] = 0; t_link[0] = 0;
    run_build(2, 1'b0, "R2");
    drive_query(4, 11, "R10", "R10");
    drive_query(12, 63, "R8", "R8");
    drive_query(0, 3, "R8", "R8");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule